// File: doc/BRIEF.md
# Dual-Channel Multimode Interval Timer

This block holds two timer channels that run independently of each other behind one small register interface. In each channel a 32-bit prescaler divides the system clock, and a 32-bit down counter counts the divided ticks. When the counter is at zero and a tick arrives, the channel expires. What happens then depends on the mode chosen at run time. In periodic mode the channel reloads and goes on. In single-shot mode it halts. In watchdog mode it sends out a one-cycle reset pulse unless software has written the service key in time.

Software writes a reload limit and a prescale divisor, and then writes the control register to start the channel. Every expiry sets a sticky event flag, and that flag drives the channel's interrupt line. Software clears the flag by writing a one to it. Once a channel has been started in watchdog mode, it stays armed until the block is reset.

Top module: `twin_timer`

## Requirements
- R1: After reset every readable register of both channels reads zero, and `irq` and `wdog_rst` are low. Register address = {channel, index[2:0]}. Index 0 is control: bit0 run, bits2:1 mode (0 periodic, 1 single-shot, 2 watchdog), read-only bit3 lock. Index 1 is the limit, index 2 the prescale divisor, index 3 the current count (read-only), index 4 the event flag in bit0, index 5 the service port (reads zero).
- R2: A control write that sets run loads the count from the limit and restarts the prescaler. The first expiry then sets the event flag exactly (limit+1)*(divisor+1) clock edges after the edge of that write. With a divisor of all ones, the count does not change within a few hundred cycles.
- R3: In periodic mode the channel reloads the limit on expiry and keeps running, so it sets the event again every (limit+1)*(divisor+1) edges.
- R4: In single-shot mode an expiry clears the run bit, and the count then holds at zero. No further event follows.
- R5: The event flag is sticky, `irq[n]` equals it, and writing bit0=1 to index 4 clears it. An expiry in the same cycle as a clear write leaves the flag set.
- R6: In watchdog mode an expiry raises `wdog_rst[n]` for exactly one cycle, on the edge that sets the event flag, and the channel then reloads and runs again.
- R7: A service write (index 5) whose data equals the key `WD_KEY` (default 32'h5A5A_C3C3) reloads the count and restarts the prescaler of a running watchdog channel. A service write with any other value has no effect. A key write on the expiry edge itself wins: no pulse and no event.
- R8: A control write that starts a channel in watchdog mode sets the lock bit. While lock is set, all control writes are ignored (control keeps reading 13). Only reset clears the lock.
- R9: A control write that carries mode code 3 is ignored entirely.
- R10: The channels are independent: the activity of one channel never changes the count or the event flag of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | {channel, register index} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 2 | Per-channel interrupt, equals the sticky event flag |
| wdog_rst | output | 2 | Per-channel one-cycle watchdog reset pulse |

## Verification
Two pairs of events can land on the same clock edge. The first is an expiry together with a software flag-clear. The bench starts a periodic channel and places the clear write exactly (limit+1) edges later. The flag must survive that edge, and a clear one cycle later must take effect. The second pair is a watchdog expiry together with a correct service write. The bench services exactly one period after a previous service and checks that no pulse and no event appear. It then checks that the next pulse comes a full period after that final write.

// File: rtl/tmr_pkg.sv
// Shared definitions for the dual-channel timer: mode codes and register indices.
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_PERIODIC = 2'd0,
        MODE_ONESHOT  = 2'd1,
        MODE_WATCHDOG = 2'd2,
        MODE_RSVD     = 2'd3
    } tmr_mode_e;

    localparam int REG_W = 3;
    localparam logic [REG_W-1:0] IDX_CTRL    = 3'd0;
    localparam logic [REG_W-1:0] IDX_LIMIT   = 3'd1;
    localparam logic [REG_W-1:0] IDX_DIV     = 3'd2;
    localparam logic [REG_W-1:0] IDX_COUNT   = 3'd3;
    localparam logic [REG_W-1:0] IDX_EVENT   = 3'd4;
    localparam logic [REG_W-1:0] IDX_SERVICE = 3'd5;
endpackage

// File: rtl/tmr_prescaler.sv
// Clock divider for one channel. tick is high for one cycle every divisor+1
// cycles while run is high. restart puts the phase back to zero.
// Assumes that divisor may change at any time; a phase beyond it ticks at once.
module tmr_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] divisor,
    output logic         tick
);
    logic [W-1:0] phase;

    // Terminal count of the divider.
    assign tick = run && (phase >= divisor);

    // Phase counter: reset by restart, stop or terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)                        phase <= '0;
        else if (restart || !run || tick)  phase <= '0;
        else                               phase <= phase + 1'b1;
    end
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: configuration registers, down counter, mode handling,
// sticky event flag and watchdog pulse. Register strobes arrive decoded.
// Assumes at most one strobe is high per cycle.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [31:0] WD_KEY = 32'h5A5A_C3C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_limit,
    input  logic              wr_div,
    input  logic              wr_event,
    input  logic              wr_service,
    input  logic [DATA_W-1:0] wdata,
    output logic              run,
    output tmr_mode_e         mode,
    output logic              lock,
    output logic [DATA_W-1:0] limit,
    output logic [DATA_W-1:0] divisor,
    output logic [DATA_W-1:0] count,
    output logic              evt,
    output logic              wd_pulse
);
    logic tick;
    logic ctrl_take;
    logic start;
    logic service_hit;
    logic expire;

    // Control write is accepted unless locked or carrying the reserved mode.
    assign ctrl_take   = wr_ctrl && !lock && (tmr_mode_e'(wdata[2:1]) != MODE_RSVD);
    assign start       = ctrl_take && wdata[0];
    // A correct key on a running watchdog channel.
    assign service_hit = wr_service && (wdata == DATA_W'(WD_KEY)) && run
                         && (mode == MODE_WATCHDOG);
    // Expiry: tick at zero count, unless a control or service write takes the edge.
    assign expire      = tick && (count == '0) && !service_hit && !ctrl_take;

    tmr_prescaler #(.W(DATA_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (start || service_hit),
        .divisor (divisor),
        .tick    (tick)
    );

    // Run, mode and lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            mode <= MODE_PERIODIC;
            lock <= 1'b0;
        end else if (ctrl_take) begin
            run  <= wdata[0];
            mode <= tmr_mode_e'(wdata[2:1]);
            lock <= wdata[0] && (tmr_mode_e'(wdata[2:1]) == MODE_WATCHDOG);
        end else if (expire && mode == MODE_ONESHOT) begin
            run  <= 1'b0;
        end
    end

    // Limit and divisor configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit   <= '0;
            divisor <= '0;
        end else begin
            if (wr_limit) limit   <= wdata;
            if (wr_div)   divisor <= wdata;
        end
    end

    // Down counter with reload on start, service and periodic or watchdog expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                      count <= '0;
        else if (start || service_hit)   count <= limit;
        else if (tick && !ctrl_take) begin
            if (count != '0)             count <= count - 1'b1;
            else if (mode != MODE_ONESHOT) count <= limit;
        end
    end

    // Sticky event flag: set has priority over a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)                    evt <= 1'b0;
        else if (expire)               evt <= 1'b1;
        else if (wr_event && wdata[0]) evt <= 1'b0;
    end

    // One-cycle reset pulse on watchdog expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) wd_pulse <= 1'b0;
        else        wd_pulse <= expire && (mode == MODE_WATCHDOG);
    end
endmodule

// File: rtl/twin_timer.sv
// Top level of the multimode timer: address decode, one tmr_channel per
// channel, and the combinational read multiplexer.
// Assumes single-cycle write strobes; reads have no side effects.
module twin_timer
    import tmr_pkg::*;
#(
    parameter int          NUM_CH = 2,
    parameter int          DATA_W = 32,
    parameter logic [31:0] WD_KEY = 32'h5A5A_C3C3,
    localparam int         CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int         ADDR_W = CH_W + REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq,
    output logic [NUM_CH-1:0] wdog_rst
);
    logic [CH_W-1:0]   sel_ch;
    logic [REG_W-1:0]  sel_idx;
    logic [DATA_W-1:0] ch_limit [NUM_CH];
    logic [DATA_W-1:0] ch_div   [NUM_CH];
    logic [DATA_W-1:0] ch_count [NUM_CH];
    tmr_mode_e         ch_mode  [NUM_CH];
    logic [NUM_CH-1:0]   ch_run_v;
    logic [NUM_CH-1:0]   ch_lock_v;
    logic [2*NUM_CH-1:0] ch_mode_v;

    assign sel_ch  = bus_addr[ADDR_W-1:REG_W];
    assign sel_idx = bus_addr[REG_W-1:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = bus_wr && (sel_ch == CH_W'(i));

        tmr_channel #(.DATA_W(DATA_W), .WD_KEY(WD_KEY)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_ctrl    (hit && sel_idx == IDX_CTRL),
            .wr_limit   (hit && sel_idx == IDX_LIMIT),
            .wr_div     (hit && sel_idx == IDX_DIV),
            .wr_event   (hit && sel_idx == IDX_EVENT),
            .wr_service (hit && sel_idx == IDX_SERVICE),
            .wdata      (bus_wdata),
            .run        (ch_run_v[i]),
            .mode       (ch_mode[i]),
            .lock       (ch_lock_v[i]),
            .limit      (ch_limit[i]),
            .divisor    (ch_div[i]),
            .count      (ch_count[i]),
            .evt        (irq[i]),
            .wd_pulse   (wdog_rst[i])
        );
        assign ch_mode_v[2*i +: 2] = ch_mode[i];
    end

    // Read multiplexer over channel and register index.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_ch == CH_W'(i)) begin
                case (sel_idx)
                    IDX_CTRL:  bus_rdata = DATA_W'({ch_lock_v[i], ch_mode[i], ch_run_v[i]});
                    IDX_LIMIT: bus_rdata = ch_limit[i];
                    IDX_DIV:   bus_rdata = ch_div[i];
                    IDX_COUNT: bus_rdata = ch_count[i];
                    IDX_EVENT: bus_rdata = DATA_W'(irq[i]);
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/twin_timer_checker.sv
// Temporal properties of twin_timer, attached through bind.
module twin_timer_checker
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] wdog_rst,
    input logic [NUM_CH-1:0] ch_run_v,
    input logic [NUM_CH-1:0] ch_lock_v,
    input logic [2*NUM_CH-1:0] ch_mode_v
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic clr_wr;
        assign clr_wr = bus_wr && bus_addr == ADDR_W'((i << REG_W) + IDX_EVENT) && bus_wdata[0];

        p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] && !clr_wr |=> irq[i]);

        p_pulse_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            wdog_rst[i] |=> !wdog_rst[i]);

        p_pulse_watchdog_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
            wdog_rst[i] |-> ch_mode_v[2*i +: 2] == MODE_WATCHDOG && irq[i]);

        p_lock_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ch_lock_v[i] |=> ch_lock_v[i] && ch_run_v[i]
                             && ch_mode_v[2*i +: 2] == MODE_WATCHDOG);

        p_oneshot_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) && ch_mode_v[2*i +: 2] == MODE_ONESHOT |-> !ch_run_v[i]);
    end
endmodule

bind twin_timer twin_timer_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .wdog_rst  (wdog_rst),
    .ch_run_v  (ch_run_v),
    .ch_lock_v (ch_lock_v),
    .ch_mode_v (ch_mode_v)
);

// File: tb/tb_twin_timer.sv
`timescale 1ns/1ps
module tb_twin_timer;
    localparam logic [31:0] KEY = 32'h5A5A_C3C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;
    logic [1:0]  wdog_rst;
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    twin_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdog_rst(wdog_rst)
    );

    typedef struct packed {
        logic [31:0] lim;
        logic [31:0] div;
        logic [1:0]  mode;
    } vec_t;
    localparam vec_t VEC [5] = '{
        '{32'd3, 32'd0, 2'd0},
        '{32'd0, 32'd0, 2'd0},
        '{32'd2, 32'd3, 2'd1},
        '{32'd5, 32'd1, 2'd0},
        '{32'd6, 32'd0, 2'd1}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic ch, input logic [2:0] idx, input logic [31:0] d);
        bus_addr = {ch, idx}; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic ch, input logic [2:0] idx, output logic [31:0] d);
        bus_addr = {ch, idx};
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq(input int ch, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!irq[ch] && n < 5000);
    endtask

    task automatic wait_wd(input int ch, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!wdog_rst[ch] && n < 5000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] c0;
        int n;
        int exp_t;
        bit no_pulse;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int ch = 0; ch < 2; ch++) begin
            for (int idx = 0; idx < 6; idx++) begin
                rd(ch[0], idx[2:0], v);
                chk(v == 0, "R1 register after reset", v, 0);
            end
        end
        chk(irq == 0 && wdog_rst == 0, "R1 outputs after reset", {irq, wdog_rst}, 0);
        @(negedge clk);

        // R2/R3/R4: vector table on channel 0
        for (int k = 0; k < 5; k++) begin
            wr(0, 3'd0, 32'd0);
            wr(0, 3'd4, 32'd1);
            wr(0, 3'd1, VEC[k].lim);
            wr(0, 3'd2, VEC[k].div);
            wr(0, 3'd0, {29'd0, VEC[k].mode, 1'b1});
            wait_irq(0, n);
            exp_t = (int'(VEC[k].lim) + 1) * (int'(VEC[k].div) + 1);
            chk(n == exp_t, "R2 edges to first expiry", n, exp_t);
        end

        // R4: single-shot halts
        rd(0, 3'd0, v);
        chk(v == 32'd2, "R4 run bit cleared", v, 2);
        rd(0, 3'd3, v);
        chk(v == 0, "R4 count holds zero", v, 0);
        @(negedge clk);
        wr(0, 3'd4, 32'd1);
        repeat (30) @(negedge clk);
        chk(irq[0] == 1'b0, "R4 no second event", irq[0], 0);

        // R2: largest divisor freezes count
        wr(0, 3'd1, 32'd5);
        wr(0, 3'd2, 32'hFFFF_FFFF);
        wr(0, 3'd0, 32'd1);
        repeat (200) @(negedge clk);
        rd(0, 3'd3, v);
        chk(v == 32'd5 && irq[0] == 1'b0, "R2 full divisor holds count", v, 5);
        @(negedge clk);
        wr(0, 3'd0, 32'd0);

        // R9: reserved mode ignored
        wr(0, 3'd0, 32'd7);
        rd(0, 3'd0, v);
        chk(v == 0, "R9 reserved mode write ignored", v, 0);
        @(negedge clk);

        // R5: expiry and clear on the same edge, then R3 second period
        wr(0, 3'd1, 32'd3);
        wr(0, 3'd2, 32'd0);
        wr(0, 3'd0, 32'd1);
        repeat (3) @(negedge clk);
        wr(0, 3'd4, 32'd1);
        chk(irq[0] == 1'b1, "R5 set beats clear", irq[0], 1);
        wr(0, 3'd4, 32'd1);
        chk(irq[0] == 1'b0, "R5 clear takes effect", irq[0], 0);
        wait_irq(0, n);
        chk(n == 3, "R3 periodic reload period", n, 3);
        wr(0, 3'd0, 32'd0);
        wr(0, 3'd4, 32'd1);
        rd(0, 3'd3, c0);
        @(negedge clk);

        // R7: watchdog on channel 1 kept alive by service
        wr(1, 3'd1, 32'd4);
        wr(1, 3'd2, 32'd1);
        wr(1, 3'd0, 32'd5);
        no_pulse = 1'b1;
        for (int s = 0; s < 4; s++) begin
            repeat (5) begin
                @(negedge clk);
                if (wdog_rst[1]) no_pulse = 1'b0;
            end
            wr(1, 3'd5, KEY);
        end
        chk(no_pulse, "R7 serviced watchdog stays quiet", no_pulse, 1);

        // R8: lock blocks control writes
        wr(1, 3'd0, 32'd0);
        rd(1, 3'd0, v);
        chk(v == 32'd13, "R8 locked control unchanged", v, 13);
        @(negedge clk);

        // R7: service on the expiry edge wins
        wr(1, 3'd5, KEY);
        repeat (9) @(negedge clk);
        wr(1, 3'd5, KEY);
        chk(wdog_rst[1] == 1'b0 && irq[1] == 1'b0, "R7 service beats expiry", {wdog_rst[1], irq[1]}, 0);

        // R6: pulse timing and width
        wait_wd(1, n);
        chk(n == 10, "R6 pulse a period after service", n, 10);
        chk(irq[1] == 1'b1, "R6 event set with pulse", irq[1], 1);
        @(negedge clk);
        chk(wdog_rst[1] == 1'b0, "R6 pulse one cycle", wdog_rst[1], 0);

        // R7: wrong key ignored
        wr(1, 3'd4, 32'd1);
        wr(1, 3'd5, 32'h1234_5678);
        wait_wd(1, n);
        chk(n == 7, "R7 wrong key does not service", n, 7);

        // R10: channel 0 untouched
        rd(0, 3'd3, v);
        chk(v == c0 && irq[0] == 1'b0, "R10 channel independence", v, c0);
        @(negedge clk);

        // R8/R1: reset clears the lock
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(1, 3'd0, v);
        chk(v == 0 && wdog_rst == 0, "R8 reset clears lock", v, 0);
        @(negedge clk);
        wr(1, 3'd0, 32'd1);
        rd(1, 3'd0, v);
        chk(v == 32'd1, "R8 control writable after reset", v, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule